// File: doc/BRIEF.md
# Outbound Bus Cycle Address Decoder

This block sits between a local request bus and the master side of a PCI-style bus. It watches every local access, claims those whose address lies in a fixed quarter of the local address space, and turns each claimed access into one bus request. The request carries a 32-bit bus address, a command code and byte enables. Addresses outside the window are not claimed. For each of them the block raises a one-cycle flag so that another decoder can route the access elsewhere.

A small control register, written through a plain register port, sets how the window is used. In memory mode, the low 30 address bits pass straight through and a two-bit programmable field fills the top of the bus address. In configuration mode, the same window carries configuration cycles. The window offset then holds a one-hot device select at bit 13 plus the device number, a function number in bits 10:8 and a dword register index in bits 7:2. These cycles are always whole-word, so narrower accesses rely on a read, merge and write sequence upstream. Configuration offsets at or above 1 MiB are refused with no bus cycle.

Top module: `pci_outbound_decoder`

## Requirements
- R1: A request is claimed only when local address bits 31:30 equal 2'b10, which covers 0x80000000 to 0xBFFFFFFF. Any other address gives a one-cycle `unclaimed` pulse and no bus request.
- R2: The outcome of a request accepted on a rising edge appears on the outputs after exactly that edge and lasts one cycle. In a cycle with no request, `bus_valid`, `unclaimed` and `cfg_reject` are all low and `bus_addr`, `bus_cmd` and `bus_be` are zero.
- R3: In memory mode, `bus_addr[29:0]` equals local address bits 29:0 and `bus_addr[31:30]` equals control bits 3:2.
- R4: Control bit 1 selects the cycle type, where 0 is memory and 1 is configuration. The command codes are 4'h6 for a memory read, 4'h7 for a memory write, 4'hA for a configuration read and 4'hB for a configuration write.
- R5: In configuration mode, a claimed request whose window offset (bits 29:0) is 0x00100000 or more gives a one-cycle `cfg_reject` pulse and no bus request. An offset of 0x000FFFFC is still issued.
- R6: A configuration bus address carries offset bits 19:2 unchanged, so the one-hot device select, function and register fields keep their positions. Bits 31:20 and 1:0 are zero.
- R7: Configuration requests drive `bus_be` to 4'hF whatever the local byte enables are. Memory requests copy `req_be` to `bus_be`.
- R8: The control register resets to zero and stores only bits 3:1 on `ctl_wr_en`. Every other bit reads back as zero. A request accepted on the same edge as a control write uses the value from before the write.
- R9: Every accepted request gives exactly one of `bus_valid`, `unclaimed` or `cfg_reject`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 32 | Control register write value |
| ctl_rd_data | output | 32 | Control register contents |
| req_valid | input | 1 | Local request present this cycle |
| req_write | input | 1 | Local request is a write |
| req_addr | input | 32 | Local request address |
| req_be | input | 4 | Local byte enables |
| bus_valid | output | 1 | Bus request issued |
| bus_addr | output | 32 | Bus address |
| bus_cmd | output | 4 | Bus command code |
| bus_be | output | 4 | Bus byte enables |
| unclaimed | output | 1 | Request was outside the window |
| cfg_reject | output | 1 | Configuration offset out of range |

## Verification
The assertions check on every cycle that:
- each request gets exactly one outcome, one cycle later, and an idle cycle gets none;
- out-of-window addresses are passed on unclaimed;
- memory addresses take their top bits from the control register as it stood when the request was accepted;
- issued configuration cycles stay below the 1 MiB limit, with full byte enables and a dword-aligned address;
- reserved control bits always read back as zero.

Only the bench scenarios show that:
- the exact addresses and commands match for chosen patterns;
- the window edges, the 0x000FFFFC and 0x00100000 offset boundaries and reserved-bit writes behave as required;
- a mode change written on the same edge as a request leaves that request in the old mode.

// File: rtl/pci_obd_pkg.sv
package pci_obd_pkg;

   typedef enum logic [3:0] {
      CMD_IDLE   = 4'h0,
      CMD_MEM_RD = 4'h6,
      CMD_MEM_WR = 4'h7,
      CMD_CFG_RD = 4'hA,
      CMD_CFG_WR = 4'hB
   } bus_cmd_e;

   function automatic bus_cmd_e pick_cmd(input logic cfg_mode, input logic is_write);
      bus_cmd_e c;
      case ({cfg_mode, is_write})
         2'b00:   c = CMD_MEM_RD;
         2'b01:   c = CMD_MEM_WR;
         2'b10:   c = CMD_CFG_RD;
         default: c = CMD_CFG_WR;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/obd_ctl_reg.sv
module obd_ctl_reg #(
   parameter int CTL_W    = 32,
   parameter int MODE_BIT = 1,
   parameter int HI_LSB   = 2,
   parameter int HI_W     = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CTL_W-1:0] wr_data,
   output logic             cfg_mode,
   output logic [HI_W-1:0]  hi_bits,
   output logic [CTL_W-1:0] rd_data
);
   if (MODE_BIT >= CTL_W || HI_LSB + HI_W > CTL_W)
      $error("obd_ctl_reg: control fields do not fit in CTL_W");
   if (MODE_BIT >= HI_LSB && MODE_BIT < HI_LSB + HI_W)
      $error("obd_ctl_reg: mode bit overlaps upper address field");

   logic            mode_q;
   logic [HI_W-1:0] hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
         hi_q   <= '0;
      end else if (wr_en) begin
         mode_q <= wr_data[MODE_BIT];
         hi_q   <= wr_data[HI_LSB +: HI_W];
      end
   end

   always_comb begin
      rd_data                  = '0;
      rd_data[MODE_BIT]        = mode_q;
      rd_data[HI_LSB +: HI_W]  = hi_q;
   end

   assign cfg_mode = mode_q;
   assign hi_bits  = hi_q;
endmodule

// File: rtl/obd_window.sv
module obd_window #(
   parameter int          ADDR_W        = 32,
   parameter int          HI_W          = 2,
   parameter logic [1:0]  WIN_TAG       = 2'b10,
   parameter int          CFG_SPAN_LOG2 = 20
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              claimed,
   output logic              cfg_off_ok
);
   localparam int OFF_W = ADDR_W - HI_W;

   if (HI_W != 2)
      $error("obd_window: window tag is two bits wide");
   if (CFG_SPAN_LOG2 < 3 || CFG_SPAN_LOG2 >= OFF_W)
      $error("obd_window: configuration span must lie inside the window");

   assign claimed    = (addr[ADDR_W-1 -: HI_W] == WIN_TAG);
   assign cfg_off_ok = (addr[OFF_W-1:CFG_SPAN_LOG2] == '0);
endmodule

// File: rtl/obd_compose.sv
module obd_compose
   import pci_obd_pkg::*;
#(
   parameter int ADDR_W        = 32,
   parameter int HI_W          = 2,
   parameter int CFG_SPAN_LOG2 = 20,
   parameter int BE_W          = ADDR_W / 8
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [BE_W-1:0]   be,
   input  logic              is_write,
   input  logic              cfg_mode,
   input  logic [HI_W-1:0]   hi_bits,
   output logic [ADDR_W-1:0] out_addr,
   output logic [BE_W-1:0]   out_be,
   output logic [3:0]        out_cmd
);
   localparam int OFF_W   = ADDR_W - HI_W;
   localparam int ALIGN_W = $clog2(BE_W);

   if (ADDR_W % 8 != 0 || BE_W * 8 != ADDR_W)
      $error("obd_compose: address width must be a whole number of byte lanes");

   logic [ADDR_W-1:0] mem_a;
   logic [ADDR_W-1:0] cfg_a;

   always_comb begin
      mem_a = {hi_bits, addr[OFF_W-1:0]};
      cfg_a = '0;
      cfg_a[CFG_SPAN_LOG2-1:ALIGN_W] = addr[CFG_SPAN_LOG2-1:ALIGN_W];
   end

   assign out_addr = cfg_mode ? cfg_a : mem_a;
   assign out_cmd  = pick_cmd(cfg_mode, is_write);

   for (genvar lane = 0; lane < BE_W; lane++) begin : g_lane
      assign out_be[lane] = cfg_mode | be[lane];
   end
endmodule

// File: rtl/pci_outbound_decoder.sv
module pci_outbound_decoder #(
   parameter int          ADDR_W        = 32,
   parameter int          CTL_W         = 32,
   parameter int          HI_W          = 2,
   parameter logic [1:0]  WIN_TAG       = 2'b10,
   parameter int          CFG_SPAN_LOG2 = 20,
   parameter int          MODE_BIT      = 1,
   parameter int          HI_LSB        = 2,
   parameter int          BE_W          = ADDR_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr_en,
   input  logic [CTL_W-1:0]  ctl_wr_data,
   output logic [CTL_W-1:0]  ctl_rd_data,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [BE_W-1:0]   req_be,
   output logic              bus_valid,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [3:0]        bus_cmd,
   output logic [BE_W-1:0]   bus_be,
   output logic              unclaimed,
   output logic              cfg_reject
);
   logic            cfg_mode;
   logic [HI_W-1:0] hi_bits;
   logic            claimed;
   logic            off_ok;
   logic [ADDR_W-1:0] nx_addr;
   logic [BE_W-1:0]   nx_be;
   logic [3:0]        nx_cmd;
   logic              issue;

   obd_ctl_reg #(
      .CTL_W(CTL_W), .MODE_BIT(MODE_BIT), .HI_LSB(HI_LSB), .HI_W(HI_W)
   ) u_ctl (
      .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr_en), .wr_data(ctl_wr_data),
      .cfg_mode(cfg_mode), .hi_bits(hi_bits), .rd_data(ctl_rd_data)
   );

   obd_window #(
      .ADDR_W(ADDR_W), .HI_W(HI_W), .WIN_TAG(WIN_TAG), .CFG_SPAN_LOG2(CFG_SPAN_LOG2)
   ) u_win (
      .addr(req_addr), .claimed(claimed), .cfg_off_ok(off_ok)
   );

   obd_compose #(
      .ADDR_W(ADDR_W), .HI_W(HI_W), .CFG_SPAN_LOG2(CFG_SPAN_LOG2), .BE_W(BE_W)
   ) u_cmp (
      .addr(req_addr), .be(req_be), .is_write(req_write), .cfg_mode(cfg_mode),
      .hi_bits(hi_bits), .out_addr(nx_addr), .out_be(nx_be), .out_cmd(nx_cmd)
   );

   assign issue = req_valid & claimed & (~cfg_mode | off_ok);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_valid  <= 1'b0;
         bus_addr   <= '0;
         bus_cmd    <= '0;
         bus_be     <= '0;
         unclaimed  <= 1'b0;
         cfg_reject <= 1'b0;
      end else begin
         bus_valid  <= issue;
         bus_addr   <= issue ? nx_addr : '0;
         bus_cmd    <= issue ? nx_cmd  : '0;
         bus_be     <= issue ? nx_be   : '0;
         unclaimed  <= req_valid & ~claimed;
         cfg_reject <= req_valid & claimed & cfg_mode & ~off_ok;
      end
   end
endmodule

// File: rtl/obd_checker.sv
module obd_checker #(
   parameter int          ADDR_W        = 32,
   parameter int          CTL_W         = 32,
   parameter int          HI_W          = 2,
   parameter logic [1:0]  WIN_TAG       = 2'b10,
   parameter int          CFG_SPAN_LOG2 = 20,
   parameter int          MODE_BIT      = 1,
   parameter int          HI_LSB        = 2,
   parameter int          BE_W          = ADDR_W / 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ctl_wr_en,
   input logic [CTL_W-1:0]  ctl_wr_data,
   input logic [CTL_W-1:0]  ctl_rd_data,
   input logic              req_valid,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic [BE_W-1:0]   req_be,
   input logic              bus_valid,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [3:0]        bus_cmd,
   input logic [BE_W-1:0]   bus_be,
   input logic              unclaimed,
   input logic              cfg_reject
);
   localparam int OFF_W = ADDR_W - HI_W;
   localparam logic [CTL_W-1:0] KEEP_MASK =
      (CTL_W'(1) << MODE_BIT) | (((CTL_W'(1) << HI_W) - 1) << HI_LSB);

   logic in_win;
   logic is_cfg_cmd;
   assign in_win     = (req_addr[ADDR_W-1 -: HI_W] == WIN_TAG);
   assign is_cfg_cmd = (bus_cmd == 4'hA) || (bus_cmd == 4'hB);

   p_unclaimed_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !in_win |=> unclaimed && !bus_valid);

   p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (bus_valid || unclaimed || cfg_reject));

   p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !bus_valid && !unclaimed && !cfg_reject);

   p_mem_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && in_win && !ctl_rd_data[MODE_BIT] |=>
         bus_valid
         && bus_addr[ADDR_W-1 -: HI_W] == $past(ctl_rd_data[HI_LSB +: HI_W])
         && bus_addr[OFF_W-1:0] == $past(req_addr[OFF_W-1:0]));

   p_cfg_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && in_win && ctl_rd_data[MODE_BIT] |=>
         (bus_valid && is_cfg_cmd) || cfg_reject);

   p_cfg_span_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && is_cfg_cmd |-> bus_addr[ADDR_W-1:CFG_SPAN_LOG2] == '0);

   p_cfg_be_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && is_cfg_cmd |-> (&bus_be) && bus_addr[1:0] == 2'b00);

   p_ctl_rsvd_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_rd_data & ~KEEP_MASK) == '0);

   p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({bus_valid, unclaimed, cfg_reject}));
endmodule

bind pci_outbound_decoder obd_checker #(
   .ADDR_W(ADDR_W), .CTL_W(CTL_W), .HI_W(HI_W), .WIN_TAG(WIN_TAG),
   .CFG_SPAN_LOG2(CFG_SPAN_LOG2), .MODE_BIT(MODE_BIT), .HI_LSB(HI_LSB), .BE_W(BE_W)
) u_obd_chk (.*);

// File: tb/tb_pci_outbound_decoder.sv
`timescale 1ns/1ps
module tb_pci_outbound_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_wr_en = 1'b0;
   logic [31:0] ctl_wr_data = '0;
   logic [31:0] ctl_rd_data;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [31:0] req_addr = '0;
   logic [3:0]  req_be = '0;
   logic        bus_valid;
   logic [31:0] bus_addr;
   logic [3:0]  bus_cmd;
   logic [3:0]  bus_be;
   logic        unclaimed;
   logic        cfg_reject;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  done    = 0;

   // reference model state
   bit          m_mode = 0;
   bit [1:0]    m_hi   = 0;
   bit [42:0]   exp_out = '0;   // {valid, addr, cmd, be, unclaimed, reject}
   string       exp_tag = "R2";

   always #2.5 clk = ~clk;

   pci_outbound_decoder dut (
      .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
      .ctl_rd_data(ctl_rd_data), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_be(req_be), .bus_valid(bus_valid), .bus_addr(bus_addr),
      .bus_cmd(bus_cmd), .bus_be(bus_be), .unclaimed(unclaimed), .cfg_reject(cfg_reject)
   );

   function automatic bit [42:0] model(input bit v, input bit w, input bit [31:0] a,
                                       input bit [3:0] be);
      bit [31:0] ba;
      bit [3:0]  cmd;
      if (!v) return '0;
      if (a[31:30] != 2'b10) return {1'b0, 32'h0, 4'h0, 4'h0, 1'b1, 1'b0};
      if (m_mode && a[29:0] >= 30'h0010_0000) return {1'b0, 32'h0, 4'h0, 4'h0, 1'b0, 1'b1};
      if (m_mode) begin
         ba  = a & 32'h000F_FFFC;
         cmd = w ? 4'hB : 4'hA;
         return {1'b1, ba, cmd, 4'hF, 1'b0, 1'b0};
      end
      ba  = {m_hi, a[29:0]};
      cmd = w ? 4'h7 : 4'h6;
      return {1'b1, ba, cmd, be, 1'b0, 1'b0};
   endfunction

   task automatic compare();
      bit [42:0] act;
      bit [31:0] exp_ctl;
      act     = {bus_valid, bus_addr, bus_cmd, bus_be, unclaimed, cfg_reject};
      exp_ctl = {28'h0, m_hi, m_mode, 1'b0};
      n_tests++;
      if (act !== exp_out) begin
         n_fail++;
         $display("FAIL %s: outputs {v,addr,cmd,be,uncl,rej} actual %h expected %h",
                  exp_tag, act, exp_out);
      end
      n_tests++;
      if (ctl_rd_data !== exp_ctl) begin
         n_fail++;
         $display("FAIL R8: ctl_rd_data actual %h expected %h", ctl_rd_data, exp_ctl);
      end
   endtask

   // one cycle: check last outcome, drive new inputs, predict
   task automatic step(input bit v, input bit w, input bit [31:0] a, input bit [3:0] be,
                       input bit cw, input bit [31:0] cd, input string tag);
      @(negedge clk);
      compare();
      req_valid   = v;
      req_write   = w;
      req_addr    = a;
      req_be      = be;
      ctl_wr_en   = cw;
      ctl_wr_data = cd;
      exp_out = model(v, w, a, be);
      exp_tag = tag;
      if (cw) begin
         m_mode = cd[1];
         m_hi   = cd[3:2];
      end
   endtask

   task automatic idle(input string tag);
      step(0, 0, 32'h0, 4'h0, 0, 32'h0, tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // reset state (R2, R8)
      idle("R2");
      idle("R2");
      // memory mode with default upper bits (R3, R4)
      step(1, 0, 32'h8000_1234, 4'hF, 0, 0, "R3");
      step(1, 1, 32'hA5A5_5A5C, 4'h3, 0, 0, "R4");
      // upper bits 3 (R3, R7)
      step(0, 0, 0, 0, 1, 32'h0000_000C, "R8");
      step(1, 1, 32'hBFFF_FFFC, 4'h5, 0, 0, "R7");
      step(1, 0, 32'h8000_0000, 4'h8, 0, 0, "R3");
      // reserved control bits ignored (R8)
      step(0, 0, 0, 0, 1, 32'hFFFF_FFF5, "R8");
      step(1, 0, 32'h9234_5678, 4'h1, 0, 0, "R3");
      idle("R2");
      // window edges (R1)
      step(1, 0, 32'h7FFF_FFFF, 4'hF, 0, 0, "R1");
      step(1, 1, 32'hC000_0000, 4'hF, 0, 0, "R1");
      step(1, 0, 32'h0000_0000, 4'hF, 0, 0, "R1");
      step(1, 1, 32'hFFFF_FFFF, 4'hF, 0, 0, "R1");
      step(1, 0, 32'hBFFF_FFFF, 4'hF, 0, 0, "R1");
      // mode write on same edge as request uses old mode (R8)
      step(1, 0, 32'h8000_2104, 4'h2, 1, 32'h0000_0002, "R8");
      // configuration cycles (R4, R6, R7)
      step(1, 0, 32'h8000_2104, 4'h2, 0, 0, "R4");
      step(1, 1, 32'h8008_0318, 4'h1, 0, 0, "R6");
      step(1, 0, 32'h8000_2003, 4'h4, 0, 0, "R6");
      step(1, 1, 32'h800F_FFFC, 4'h1, 0, 0, "R5");
      // out-of-range offsets (R5)
      step(1, 0, 32'h8010_0000, 4'hF, 0, 0, "R5");
      step(1, 1, 32'hBFFF_0000, 4'hF, 0, 0, "R5");
      step(1, 0, 32'h4000_0000, 4'hF, 0, 0, "R1");
      idle("R2");
      // back to memory mode with upper bits 2
      step(1, 1, 32'h8000_0040, 4'hC, 1, 32'h0000_0008, "R8");
      step(1, 1, 32'h8000_0040, 4'hC, 0, 0, "R3");
      // mixed traffic (R9)
      for (int i = 0; i < 3000; i++) begin
         bit [31:0] a;
         bit [31:0] r;
         r = $urandom;
         a = $urandom;
         if (r[3:2] == 2'b00) a[29:20] = '0;
         step(r[0] | r[1], r[4], a, r[8:5], (r[12:9] == 4'h0), $urandom, "R9");
      end
      idle("R2");
      idle("R2");
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(5ns * 150000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule